// File: doc/BRIEF.md
# Byte-Lane Load/Store Overlap Detector

This block keeps a small set of slots, one for each in-flight load or store, and reports which pairs of slots may touch the same bytes. It does not compare full addresses. It compares only a middle slice of each address. The low four address bits, together with the access size, become a 16-bit byte-lane mask, and two slots clash only when their slices are equal and their lane masks share a bit. The result is conservative. A clash that is reported but not real costs only lost parallelism. A real overlap is never missed, so an access that runs past the last lane of its 16-byte group is treated as clashing with every other live slot.

Each slot has its own write strobe. On a strobe, the slot captures an address, a size and an enable, and keeps them until its next strobe. The clash matrix is combinational from this stored state. It appears in the cycle after the capturing clock edge. Issue logic reads one row per slot to decide which accesses must be serialised.

Top module: `ovl_detect`

## Requirements
- R1: After a synchronous reset, every slot is disabled and `clash_o` is all zero.
- R2: A slot takes in `addr_i`, `size_i` and `en_i` only in a cycle where its `wr_i` bit is 1. In every other cycle it keeps the values it holds, and the changing inputs have no effect on `clash_o`.
- R3: Only address bits ADDR_W-1 down to 4 (11:4 by default) are checked for equality. When two slots differ in any of those bits, they do not clash, unless R8 applies.
- R4: The size code is 2 bits: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. The lane mask is ((1<<bytes)-1) shifted left by address bits 3:0, so a 1-byte access sets exactly one lane and an 8-byte access sets eight contiguous lanes.
- R5: Two enabled slots with equal slices clash if and only if their lane masks share at least one set bit. Adjacent accesses that do not overlap do not clash.
- R6: A slot never clashes with itself: `clash_o[i*N+i]` is always 0.
- R7: A slot whose captured enable is 0 never appears in any row or column of `clash_o`.
- R8: If a slot's access runs past lane 15, that slot clashes with every other enabled slot, whatever their slices.
- R9: The matrix is symmetric: `clash_o[i*N+j]` equals `clash_o[j*N+i]`.
- R10: Row i of `clash_o` is bits i*N+N-1 down to i*N, and bit j of that row flags slot j. The matrix reflects state captured at the previous clock edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | NUM_SLOTS | Per-slot capture strobe |
| en_i | input | NUM_SLOTS | Per-slot enable value to capture |
| addr_i | input | NUM_SLOTS*ADDR_W | Per-slot address bits ADDR_W-1:0, slot k at bits k*ADDR_W+ADDR_W-1 : k*ADDR_W |
| size_i | input | 2*NUM_SLOTS | Per-slot size code (R4), slot k at bits 2k+1:2k |
| clash_o | output | NUM_SLOTS*NUM_SLOTS | Clash matrix, row i at bits i*N+N-1 : i*N |

## Verification
The hardest case to reach is the lane spill. It needs an offset and a size whose sum passes 16 bytes. When it fires, it must override a slice mismatch and still respect a disabled partner. The stimulus first builds a four-slot pattern with mixed slices and partial lane overlaps. It then rewrites one slot with a 2-byte access at offset 15 and a different slice, and checks the full matrix. Separately, vector pairs with offsets 12, 14 and 15 separate a true spill from an access that ends exactly at lane 15.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  localparam int LANES     = 16;
  localparam int LANE_ABITS = 4;
  localparam int MAX_BYTES = 8;
  localparam int FULL_W    = LANES + MAX_BYTES - 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  function automatic logic [3:0] size_bytes(input acc_size_e sz);
    case (sz)
      SZ_BYTE: size_bytes = 4'd1;
      SZ_HALF: size_bytes = 4'd2;
      SZ_WORD: size_bytes = 4'd4;
      default: size_bytes = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/ovl_lane_map.sv
module ovl_lane_map
  import ovl_pkg::*;
(
  input  logic [LANE_ABITS-1:0] offs_i,
  input  acc_size_e             size_i,
  output logic [LANES-1:0]      lanes_o,
  output logic                  spill_o
);

  logic [FULL_W-1:0] base;
  logic [FULL_W-1:0] full;
  logic [3:0]        nbytes;

  always_comb begin
    nbytes = size_bytes(size_i);
    base   = '0;
    for (int b = 0; b < MAX_BYTES; b++) begin
      if (b < int'(nbytes)) base[b] = 1'b1;
    end
    full    = base << offs_i;
    lanes_o = full[LANES-1:0];
    spill_o = |full[FULL_W-1:LANES];
  end

  // R4: the mask (plus spilled part) carries exactly as many bits as bytes
  always_comb begin
    assert_lane_count_R4: assert ($countones(full) == int'(nbytes));
  end

endmodule

// File: rtl/ovl_slot.sv
module ovl_slot
  import ovl_pkg::*;
#(
  parameter int ADDR_W  = 12,
  localparam int SLICE_W = ADDR_W - LANE_ABITS
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic               en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         size_i,
  output logic               en_q,
  output logic [SLICE_W-1:0] slice_q,
  output logic [LANES-1:0]   lanes_q,
  output logic               spill_q
);

  logic [LANES-1:0] lanes_d;
  logic             spill_d;

  ovl_lane_map u_map (
    .offs_i  (addr_i[LANE_ABITS-1:0]),
    .size_i  (acc_size_e'(size_i)),
    .lanes_o (lanes_d),
    .spill_o (spill_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      slice_q <= '0;
      lanes_q <= '0;
      spill_q <= 1'b0;
    end else if (wr_i) begin
      en_q    <= en_i;
      slice_q <= addr_i[ADDR_W-1:LANE_ABITS];
      lanes_q <= lanes_d;
      spill_q <= spill_d;
    end
  end

  // R2: capture follows the strobe
  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !rst) |=> (en_q == $past(en_i)) &&
                       (slice_q == $past(addr_i[ADDR_W-1:LANE_ABITS])));

  // R2: without a strobe the slot state does not move
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !rst) |=> $stable(en_q) && $stable(slice_q) &&
                        $stable(lanes_q) && $stable(spill_q));

endmodule

// File: rtl/ovl_pair_cmp.sv
module ovl_pair_cmp
  import ovl_pkg::*;
#(
  parameter int SLICE_W = 8
)(
  input  logic               en_a,
  input  logic [SLICE_W-1:0] slice_a,
  input  logic [LANES-1:0]   lanes_a,
  input  logic               spill_a,
  input  logic               en_b,
  input  logic [SLICE_W-1:0] slice_b,
  input  logic [LANES-1:0]   lanes_b,
  input  logic               spill_b,
  output logic               clash_o
);

  logic same_slice;
  logic lane_hit;
  logic any_spill;

  always_comb begin
    same_slice = (slice_a == slice_b);
    lane_hit   = |(lanes_a & lanes_b);
    any_spill  = spill_a | spill_b;
    clash_o    = en_a & en_b & ((same_slice & lane_hit) | any_spill);
  end

endmodule

// File: rtl/ovl_detect.sv
module ovl_detect
  import ovl_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 12,
  localparam int SLICE_W  = ADDR_W - LANE_ABITS
)(
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SLOTS-1:0]          wr_i,
  input  logic [NUM_SLOTS-1:0]          en_i,
  input  logic [NUM_SLOTS*ADDR_W-1:0]   addr_i,
  input  logic [2*NUM_SLOTS-1:0]        size_i,
  output logic [NUM_SLOTS*NUM_SLOTS-1:0] clash_o
);

  logic [NUM_SLOTS-1:0]  en_q;
  logic [SLICE_W-1:0]    slice_q [NUM_SLOTS];
  logic [LANES-1:0]      lanes_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]  spill_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    ovl_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (wr_i[s]),
      .en_i    (en_i[s]),
      .addr_i  (addr_i[s*ADDR_W +: ADDR_W]),
      .size_i  (size_i[2*s +: 2]),
      .en_q    (en_q[s]),
      .slice_q (slice_q[s]),
      .lanes_q (lanes_q[s]),
      .spill_q (spill_q[s])
    );
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_row
    for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_col
      if (i == j) begin : g_self
        assign clash_o[i*NUM_SLOTS + j] = 1'b0;
      end else begin : g_pair
        ovl_pair_cmp #(.SLICE_W(SLICE_W)) u_cmp (
          .en_a    (en_q[i]),
          .slice_a (slice_q[i]),
          .lanes_a (lanes_q[i]),
          .spill_a (spill_q[i]),
          .en_b    (en_q[j]),
          .slice_b (slice_q[j]),
          .lanes_b (lanes_q[j]),
          .spill_b (spill_q[j]),
          .clash_o (clash_o[i*NUM_SLOTS + j])
        );

        // R9: independently built comparators for (i,j) and (j,i) agree
        assert_symmetric_R9: assert property (@(posedge clk) disable iff (rst)
          clash_o[i*NUM_SLOTS + j] == clash_o[j*NUM_SLOTS + i]);

        // R7: a disabled partner never shows up
        assert_disabled_silent_R7: assert property (@(posedge clk) disable iff (rst)
          !en_q[j] |-> !clash_o[i*NUM_SLOTS + j]);

        // R8: a spilling live slot flags every live partner
        assert_spill_wins_R8: assert property (@(posedge clk) disable iff (rst)
          (spill_q[i] && en_q[i] && en_q[j]) |-> clash_o[i*NUM_SLOTS + j]);

        // R5: without spill, a clash implies equal slices and shared lanes
        assert_needs_overlap_R5: assert property (@(posedge clk) disable iff (rst)
          (clash_o[i*NUM_SLOTS + j] && !spill_q[i] && !spill_q[j]) |->
            ((slice_q[i] == slice_q[j]) && ((lanes_q[i] & lanes_q[j]) != '0)));
      end
    end
  end

  // R1: the cycle after reset the matrix is empty
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (clash_o == '0));

endmodule

// File: tb/ovl_detect_tb_top.sv
module ovl_detect_tb_top;

  localparam int N  = 4;
  localparam int AW = 12;
  localparam int NV = 12;

  logic             clk = 1'b0;
  logic             rst;
  logic [N-1:0]     wr_i;
  logic [N-1:0]     en_i;
  logic [N*AW-1:0]  addr_i;
  logic [2*N-1:0]   size_i;
  logic [N*N-1:0]   clash_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  ovl_detect #(.NUM_SLOTS(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_i(wr_i), .en_i(en_i),
    .addr_i(addr_i), .size_i(size_i), .clash_o(clash_o)
  );

  // {addr A, size A, addr B, size B, expected clash}
  localparam logic [28:0] VEC [NV] = '{
    {12'h100, 2'd0, 12'h100, 2'd0, 1'b1},  // R4 same byte
    {12'h100, 2'd0, 12'h101, 2'd0, 1'b0},  // R4 neighbour byte
    {12'h100, 2'd3, 12'h107, 2'd0, 1'b1},  // R4 last lane of dword
    {12'h100, 2'd3, 12'h108, 2'd3, 1'b0},  // R5 adjacent dwords
    {12'h104, 2'd2, 12'h106, 2'd1, 1'b1},  // R5 partial overlap
    {12'h100, 2'd0, 12'h110, 2'd0, 1'b0},  // R3 slice bit 4 differs
    {12'h800, 2'd0, 12'h000, 2'd0, 1'b0},  // R3 top slice bit differs
    {12'h10C, 2'd3, 12'h800, 2'd0, 1'b1},  // R8 spill beats slice
    {12'h10E, 2'd1, 12'h20E, 2'd1, 1'b0},  // R8 ends at lane 15, no spill
    {12'h10F, 2'd1, 12'hF00, 2'd0, 1'b1},  // R8 one-lane spill
    {12'h102, 2'd1, 12'h104, 2'd2, 1'b0},  // R5 touching halves
    {12'h103, 2'd1, 12'h104, 2'd2, 1'b1}   // R5 misaligned half
  };

  task automatic check(input string req, input logic [N*N-1:0] act,
                       input logic [N*N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_slot(input int k, input logic [AW-1:0] a,
                            input logic [1:0] sz, input logic en);
    @(negedge clk);
    wr_i                 = '0;
    wr_i[k]              = 1'b1;
    en_i[k]              = en;
    addr_i[k*AW +: AW]   = a;
    size_i[2*k +: 2]     = sz;
    @(negedge clk);
    wr_i = '0;
  endtask

  initial begin
    rst = 1'b1; wr_i = '0; en_i = '0; addr_i = '0; size_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", clash_o, '0);

    for (int v = 0; v < NV; v++) begin
      logic [N*N-1:0] exp;
      write_slot(0, VEC[v][28:17], VEC[v][16:15], 1'b1);
      write_slot(1, VEC[v][14:3],  VEC[v][2:1],   1'b1);
      exp = '0;
      exp[0*N+1] = VEC[v][0];
      exp[1*N+0] = VEC[v][0];
      check($sformatf("R5/R9 vector %0d", v), clash_o, exp);
    end

    // R10 four-slot layout
    write_slot(0, 12'h100, 2'd3, 1'b1);
    write_slot(1, 12'h104, 2'd0, 1'b1);
    write_slot(2, 12'h300, 2'd0, 1'b1);
    write_slot(3, 12'h106, 2'd1, 1'b1);
    check("R10 matrix layout", clash_o, 16'h101A);

    // R7 disabled slot vanishes
    write_slot(0, 12'h100, 2'd3, 1'b0);
    check("R7 disabled slot", clash_o, 16'h0000);

    // R2 inputs move without strobe
    @(negedge clk);
    en_i = '1; addr_i = {N{12'h100}}; size_i = {N{2'd3}};
    @(negedge clk);
    @(negedge clk);
    check("R2 hold without strobe", clash_o, 16'h0000);

    write_slot(0, 12'h100, 2'd3, 1'b1);
    check("R2 capture on strobe", clash_o, 16'h101A);

    // R8 spill across slices, R6 diagonal stays clear
    write_slot(2, 12'h30F, 2'd1, 1'b1);
    check("R8 spill on all partners", clash_o, 16'h5B5E);
    check("R6 no self clash", clash_o & 16'h8421, 16'h0000);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset clears slots", clash_o, '0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule